// File: doc/BRIEF.md
# Tranche Loss Mapper and Accumulator

This block turns per-time-step collateral-pool losses of Monte-Carlo paths into the loss of one tranche, and sums those results over all paths. A tranche is set by two unsigned thresholds, a lower one (`attach_i`) and an upper one (`detach_i`). The tranche width is upper minus lower. Each pool loss is clamped into that window to give the tranche loss. The block also gives the premium base, which is the part of the width still earning premium (width minus tranche loss).

One sample arrives per cycle. Each sample carries a time-step index. The two results are added, for that step, into two register files of saturating accumulators that are wider than the input. A pricing run begins with `clear_i`. It ends with `done_i`, which freezes the sums. After that, a read port returns both sums for any step, so that downstream logic can discount them and divide them by the path count.

Top module: `tranche_loss_accum`

## Requirements
- R1: A pool loss at or below `attach_i` gives a tranche loss of zero and a premium base equal to the full width (`detach_i - attach_i`).
- R2: A pool loss at or above `detach_i` gives a tranche loss equal to the full width and a premium base of zero.
- R3: A pool loss strictly between the thresholds gives a tranche loss of pool loss minus `attach_i`, and a premium base of `detach_i` minus pool loss.
- R4: Each valid sample adds its tranche loss and its premium base to the entries indexed by `step_i`. The new sums show on `rd_loss_o` and `rd_prem_o` (combinational on `rd_step_i`) after the second rising edge following the sample.
- R5: `clear_i` zeroes every sum, `overflow_o` and `frozen_o` at the next edge. A sample presented in the same cycle as `clear_i` is the first sample of the new run. A sample from the cycle before `clear_i` is dropped. `clear_i` has priority over `done_i`.
- R6: `done_i` sets `frozen_o` at the next edge. Samples presented in the same cycle as `done_i` or later are not accumulated until the next clear. A sample from the cycle before `done_i` is still accumulated.
- R7: An accumulator never wraps. A sum that would exceed 2^ACC_W-1 stays at 2^ACC_W-1. Any such event sets `overflow_o`, which stays set until clear or reset.
- R8: When `attach_i > detach_i`, `config_error_o` is 1 after the next edge, and a sample taken in that cycle adds zero to both sums.
- R9: After reset every sum reads zero and `frozen_o`, `overflow_o` and `config_error_o` are 0.
- R10: With `valid_i` low no sum changes, whatever `pool_loss_i` and `step_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Start a new pricing run |
| done_i | input | 1 | Last path finished; freeze sums |
| attach_i | input | LOSS_W | Lower tranche threshold |
| detach_i | input | LOSS_W | Upper tranche threshold |
| valid_i | input | 1 | Sample valid |
| step_i | input | STEP_W | Time-step index of the sample |
| pool_loss_i | input | LOSS_W | Collateral-pool loss, unsigned fixed point |
| rd_step_i | input | STEP_W | Step index to read |
| rd_loss_o | output | ACC_W | Summed tranche loss of the read step |
| rd_prem_o | output | ACC_W | Summed premium base of the read step |
| frozen_o | output | 1 | Sums frozen after done |
| overflow_o | output | 1 | Sticky saturation flag |
| config_error_o | output | 1 | Lower threshold above upper threshold |

## Verification
A sample is mapped at the first edge after it is presented. It reaches the sum at the second edge. The read outputs are combinational, so a new sum can be seen in the half cycle after that second edge. The flags change one edge after `clear_i`, `done_i` or a bad threshold pair. The bench drives inputs on falling edges and updates its model one step per rising edge, using the same one-stage delay. It compares every output on the following falling edge. Because of this, a result that comes a cycle early or a cycle late is reported. Directed sequences put `done_i`, `clear_i` and saturation next to in-flight samples. Read sweeps then compare every step entry.

// File: rtl/tla_pkg.sv
package tla_pkg;
  typedef enum logic [1:0] {
    ZONE_BELOW  = 2'd0,
    ZONE_INSIDE = 2'd1,
    ZONE_ABOVE  = 2'd2,
    ZONE_BADCFG = 2'd3
  } zone_e;
endpackage

// File: rtl/tla_sat_add.sv
module tla_sat_add #(
  parameter int VAL_W = 42,
  parameter int ACC_W = 54
) (
  input  logic [ACC_W-1:0] sum_i,
  input  logic [VAL_W-1:0] val_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             sat_o
);
  localparam int PAD_W = ACC_W - VAL_W;

  logic [ACC_W:0] wide;

  always_comb begin
    wide  = {1'b0, sum_i} + {1'b0, {PAD_W{1'b0}}, val_i};
    sat_o = wide[ACC_W];
    sum_o = wide[ACC_W] ? {ACC_W{1'b1}} : wide[ACC_W-1:0];
  end
endmodule

// File: rtl/tla_tranche_map.sv
module tla_tranche_map
  import tla_pkg::*;
#(
  parameter int LOSS_W = 42,
  parameter int STEP_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [LOSS_W-1:0] pool_i,
  input  logic [LOSS_W-1:0] attach_i,
  input  logic [LOSS_W-1:0] detach_i,
  output logic              valid_o,
  output logic [STEP_W-1:0] step_o,
  output logic [LOSS_W-1:0] loss_o,
  output logic [LOSS_W-1:0] prem_o,
  output logic              cfg_err_o
);
  zone_e             zone;
  logic [LOSS_W-1:0] width;
  logic [LOSS_W-1:0] loss_d;
  logic [LOSS_W-1:0] width_q;

  always_comb begin
    width = detach_i - attach_i;
    if (attach_i > detach_i)        zone = ZONE_BADCFG;
    else if (pool_i <= attach_i)    zone = ZONE_BELOW;
    else if (pool_i >= detach_i)    zone = ZONE_ABOVE;
    else                            zone = ZONE_INSIDE;
  end

  always_comb begin
    unique case (zone)
      ZONE_BELOW:  loss_d = '0;
      ZONE_INSIDE: loss_d = pool_i - attach_i;
      ZONE_ABOVE:  loss_d = width;
      default:     loss_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      step_o    <= '0;
      loss_o    <= '0;
      prem_o    <= '0;
      width_q   <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      step_o    <= step_i;
      cfg_err_o <= (zone == ZONE_BADCFG);
      loss_o    <= loss_d;
      // a bad threshold pair forces both results to zero
      prem_o    <= (zone == ZONE_BADCFG) ? '0 : width - loss_d;
      width_q   <= (zone == ZONE_BADCFG) ? '0 : width;
    end
  end

  AST_LOSS_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (LOSS_W'(loss_o + prem_o) == width_q)); // R3
  AST_LOSS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (loss_o <= width_q)); // R2
  AST_CFG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (loss_o == '0 && prem_o == '0)); // R8
endmodule

// File: rtl/tla_step_accum.sv
module tla_step_accum #(
  parameter int VAL_W  = 42,
  parameter int ACC_W  = 54,
  parameter int DEPTH  = 64,
  parameter int STEP_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              freeze_i,
  input  logic              valid_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [VAL_W-1:0]  loss_i,
  input  logic [VAL_W-1:0]  prem_i,
  input  logic [STEP_W-1:0] rd_step_i,
  output logic [ACC_W-1:0]  rd_loss_o,
  output logic [ACC_W-1:0]  rd_prem_o,
  output logic              overflow_o
);
  localparam int LANES = 2;

  logic                        wr_en;
  logic [LANES-1:0][VAL_W-1:0] lane_val;
  logic [LANES-1:0][ACC_W-1:0] lane_rd;
  logic [LANES-1:0]            lane_sat;

  assign wr_en       = valid_i && !freeze_i && (32'(step_i) < DEPTH);
  assign lane_val[0] = loss_i;
  assign lane_val[1] = prem_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ACC_W-1:0] mem_q [DEPTH];
    logic [ACC_W-1:0] cur;
    logic [ACC_W-1:0] nxt;

    assign cur        = (32'(step_i) < DEPTH) ? mem_q[step_i] : '0;
    assign lane_rd[l] = (32'(rd_step_i) < DEPTH) ? mem_q[rd_step_i] : '0;

    tla_sat_add #(
      .VAL_W(VAL_W),
      .ACC_W(ACC_W)
    ) u_add (
      .sum_i(cur),
      .val_i(lane_val[l]),
      .sum_o(nxt),
      .sat_o(lane_sat[l])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (clear_i) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_en) begin
        mem_q[step_i] <= nxt;
      end
    end
  end

  assign rd_loss_o = lane_rd[0];
  assign rd_prem_o = lane_rd[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      overflow_o <= 1'b0;
    else if (clear_i)                 overflow_o <= 1'b0;
    else if (wr_en && (|lane_sat))    overflow_o <= 1'b1;
  end

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clear_i) |=> overflow_o); // R7
  AST_SAT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && (|lane_sat) && !clear_i) |=> overflow_o); // R7
endmodule

// File: rtl/tranche_loss_accum.sv
module tranche_loss_accum #(
  parameter int LOSS_W    = 42,
  parameter int ACC_W     = 54,
  parameter int MAX_STEPS = 64,
  localparam int STEP_W   = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              done_i,
  input  logic [LOSS_W-1:0] attach_i,
  input  logic [LOSS_W-1:0] detach_i,
  input  logic              valid_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [LOSS_W-1:0] pool_loss_i,
  input  logic [STEP_W-1:0] rd_step_i,
  output logic [ACC_W-1:0]  rd_loss_o,
  output logic [ACC_W-1:0]  rd_prem_o,
  output logic              frozen_o,
  output logic              overflow_o,
  output logic              config_error_o
);
  logic              map_valid;
  logic [STEP_W-1:0] map_step;
  logic [LOSS_W-1:0] map_loss;
  logic [LOSS_W-1:0] map_prem;

  tla_tranche_map #(
    .LOSS_W(LOSS_W),
    .STEP_W(STEP_W)
  ) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .step_i   (step_i),
    .pool_i   (pool_loss_i),
    .attach_i (attach_i),
    .detach_i (detach_i),
    .valid_o  (map_valid),
    .step_o   (map_step),
    .loss_o   (map_loss),
    .prem_o   (map_prem),
    .cfg_err_o(config_error_o)
  );

  // run control: clear beats done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      frozen_o <= 1'b0;
    else if (clear_i) frozen_o <= 1'b0;
    else if (done_i)  frozen_o <= 1'b1;
  end

  tla_step_accum #(
    .VAL_W (LOSS_W),
    .ACC_W (ACC_W),
    .DEPTH (MAX_STEPS),
    .STEP_W(STEP_W)
  ) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .freeze_i  (frozen_o),
    .valid_i   (map_valid),
    .step_i    (map_step),
    .loss_i    (map_loss),
    .prem_i    (map_prem),
    .rd_step_i (rd_step_i),
    .rd_loss_o (rd_loss_o),
    .rd_prem_o (rd_prem_o),
    .overflow_o(overflow_o)
  );

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (rd_loss_o == '0 && rd_prem_o == '0 && !frozen_o && !overflow_o)); // R5
  AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && !clear_i) |=> (frozen_o && (rd_step_i != $past(rd_step_i) ||
                                 ($stable(rd_loss_o) && $stable(rd_prem_o))))); // R6
  AST_DONE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !clear_i) |=> frozen_o); // R6
endmodule

// File: tb/tranche_loss_accum_bench.sv
module tranche_loss_accum_bench;
  localparam int LW = 42;
  localparam int AW = 46;
  localparam int NS = 64;
  localparam int SW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clear_i = 1'b0;
  logic          done_i = 1'b0;
  logic [LW-1:0] attach_i = '0;
  logic [LW-1:0] detach_i = '0;
  logic          valid_i = 1'b0;
  logic [SW-1:0] step_i = '0;
  logic [LW-1:0] pool_loss_i = '0;
  logic [SW-1:0] rd_step_i = '0;
  logic [AW-1:0] rd_loss_o;
  logic [AW-1:0] rd_prem_o;
  logic          frozen_o;
  logic          overflow_o;
  logic          config_error_o;

  always #4 clk_i = ~clk_i;

  tranche_loss_accum #(
    .LOSS_W(LW),
    .ACC_W (AW),
    .MAX_STEPS(NS)
  ) u_tranche_loss_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .done_i(done_i),
    .attach_i(attach_i), .detach_i(detach_i), .valid_i(valid_i),
    .step_i(step_i), .pool_loss_i(pool_loss_i), .rd_step_i(rd_step_i),
    .rd_loss_o(rd_loss_o), .rd_prem_o(rd_prem_o), .frozen_o(frozen_o),
    .overflow_o(overflow_o), .config_error_o(config_error_o)
  );

  int     checks = 0;
  int     failures = 0;
  int     cycles = 0;
  string  req = "R9";
  longint m_loss [NS];
  longint m_prem [NS];
  bit     m_ovf, m_frz, m_cfg, p_v;
  longint p_l, p_p;
  int     p_s;
  longint acc_max;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void map_ref(longint a, longint d, longint p,
                                  output longint l, output longint pr);
    longint w;
    if (a > d) begin l = 0; pr = 0; end
    else begin
      w = d - a;
      if (p <= a) l = 0;
      else if (p >= d) l = w;
      else l = p - a;
      pr = w - l;
    end
  endfunction

  function automatic longint sat(longint s, longint v, inout bit ovf);
    if (s + v > acc_max) begin ovf = 1'b1; return acc_max; end
    return s + v;
  endfunction

  task automatic model_edge();
    longint l, pr;
    if (clear_i) begin
      for (int i = 0; i < NS; i++) begin m_loss[i] = 0; m_prem[i] = 0; end
      m_ovf = 0; m_frz = 0;
    end else begin
      if (p_v && !m_frz) begin
        m_loss[p_s] = sat(m_loss[p_s], p_l, m_ovf);
        m_prem[p_s] = sat(m_prem[p_s], p_p, m_ovf);
      end
      if (done_i) m_frz = 1;
    end
    m_cfg = (attach_i > detach_i);
    map_ref(longint'(attach_i), longint'(detach_i), longint'(pool_loss_i), l, pr);
    p_v = valid_i; p_s = int'(step_i); p_l = l; p_p = pr;
  endtask

  task automatic compare();
    chk(req, "rd_loss", longint'(rd_loss_o), m_loss[rd_step_i]);
    chk(req, "rd_prem", longint'(rd_prem_o), m_prem[rd_step_i]);
    chk(req, "frozen", longint'(frozen_o), longint'(m_frz));
    chk(req, "overflow", longint'(overflow_o), longint'(m_ovf));
    chk(req, "config_error", longint'(config_error_o), longint'(m_cfg));
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    model_edge();
    @(negedge clk_i);
    compare();
  endtask

  task automatic sample(int s, longint p);
    valid_i = 1'b1; step_i = SW'(s); pool_loss_i = LW'(p);
    tick();
    valid_i = 1'b0;
  endtask

  task automatic sweep();
    valid_i = 1'b0;
    for (int i = 0; i < NS; i++) begin
      rd_step_i = SW'(i);
      tick();
    end
  endtask

  initial begin
    acc_max = (longint'(1) << AW) - 1;
    for (int i = 0; i < NS; i++) begin m_loss[i] = 0; m_prem[i] = 0; end
    m_ovf = 0; m_frz = 0; m_cfg = 0; p_v = 0; p_l = 0; p_p = 0; p_s = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9: reset state
    req = "R9";
    compare();
    sweep();

    attach_i = LW'(30000); detach_i = LW'(60000);
    req = "R1";
    sample(0, 0); sample(0, 30000); sample(1, 10000);
    req = "R2";
    sample(2, 60000); sample(2, 90000);
    req = "R3";
    sample(3, 40000); sample(3, 59999); sample(4, 30001);
    tick(); tick();
    rd_step_i = SW'(3);
    tick();
    chk("R3", "mezzanine loss", longint'(rd_loss_o), 10000 + 29999);
    req = "R4";
    sweep();

    // R4: many paths across all steps
    for (int path = 0; path < 40; path++)
      for (int s = 0; s < 8; s++)
        sample((s * 9 + path) % NS, longint'($urandom_range(0, 80000)));
    sweep();

    // R10: valid low, noisy inputs
    req = "R10";
    for (int i = 0; i < 30; i++) begin
      step_i = SW'($urandom_range(0, NS - 1));
      pool_loss_i = LW'($urandom_range(0, 80000));
      rd_step_i = SW'(i % NS);
      tick();
    end

    // R6: done with in-flight sample and same-cycle sample
    req = "R6";
    valid_i = 1'b1; step_i = SW'(5); pool_loss_i = LW'(45000);
    tick();
    done_i = 1'b1; step_i = SW'(6); pool_loss_i = LW'(50000);
    tick();
    done_i = 1'b0; step_i = SW'(5); pool_loss_i = LW'(70000);
    tick(); tick();
    valid_i = 1'b0;
    sweep();

    // R5: clear, in-flight dropped, same-cycle sample kept
    req = "R5";
    valid_i = 1'b1; step_i = SW'(7); pool_loss_i = LW'(55000);
    tick();
    clear_i = 1'b1; done_i = 1'b1; step_i = SW'(8); pool_loss_i = LW'(41000);
    tick();
    clear_i = 1'b0; done_i = 1'b0; valid_i = 1'b0;
    tick();
    sweep();

    // R8: bad threshold pair
    req = "R8";
    attach_i = LW'(70000); detach_i = LW'(20000);
    sample(9, 50000); sample(9, 90000);
    tick();
    rd_step_i = SW'(9);
    tick();
    attach_i = LW'(10000); detach_i = LW'(20000);
    sample(9, 15000);
    tick(); tick();
    sweep();

    // R7: saturation and sticky flag
    req = "R7";
    attach_i = '0; detach_i = {LW{1'b1}};
    rd_step_i = SW'(12);
    for (int i = 0; i < 20; i++) sample(12, (longint'(1) << LW) - 1);
    tick(); tick();
    chk("R7", "saturated sum", longint'(rd_loss_o), acc_max);
    sample(13, 5);
    tick(); tick();
    req = "R5";
    clear_i = 1'b1;
    tick();
    clear_i = 1'b0;
    tick();
    chk("R5", "overflow after clear", longint'(overflow_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule